// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level page structure whose first level sits at a directory base frame supplied by the surrounding control logic. A requester hands over one linear address at a time with a ready/valid handshake, together with a write flag and a user-mode flag. The walker then reads the directory entry and the table entry through a single 32-bit memory port. It writes usage bits back into those entries where the access calls for it. It finishes with a one-cycle done pulse that carries either the physical address or a fault code.

With paging turned off, the block returns the linear address unchanged and does not touch memory. A walk can stop at either level with a fault: the entry may be marked absent, or a user-mode access may not be permitted. The faulting linear address stays in a register, where a handler can read it.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each taken request produces exactly one single-cycle `done` pulse, and `req_ready` stays low until that pulse has ended.
- R2: When `paging_en` is low at acceptance, `done` rises in the cycle after acceptance with `done_fault` low and `done_paddr` equal to the linear address. No memory access is made.
- R3: The directory entry is read at `{dir_frame, lin[31:22], 2'b00}`. The table entry is read at `{pde[31:12], lin[21:12], 2'b00}`. A successful walk returns `{pte[31:12], lin[11:0]}`.
- R4: An entry whose present bit (bit 0) is 0, at either level, ends the walk with a fault. No further memory access is made and nothing is written back.
- R5: On a successful check at a level, the accessed bit (bit 5) of that entry is set by a memory write before `done`. The write is made only when the bit was clear.
- R6: The dirty bit (bit 6) is set only in the table entry, and only for a write request. Bit 6 of a directory entry is never changed. An entry is written back only when its value changes.
- R7: Supervisor requests are allowed on every present page. A user request needs the user bit (bit 2) set at both levels. A user write also needs the read/write bit (bit 1) set at both levels. A violation ends the walk with a protection fault and writes back nothing at the failing level.
- R8: `done_fcode` is defined when `done_fault` is high. Bit 0 is 1 for a protection fault and 0 for an absent entry. Bit 1 is the request's write flag. Bit 2 is the request's user flag.
- R9: `fault_addr` resets to 0 and holds the linear address of the most recent faulting request from the `done` cycle of that request onward. Requests that do not fault leave it unchanged.
- R10: Once raised, `mem_req` holds with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack` is seen. Read data is taken in the `mem_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en | input | 1 | Translation enable, sampled at request acceptance |
| dir_frame | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request is made in user mode |
| done | output | 1 | Single-cycle completion pulse |
| done_fault | output | 1 | Completion is a fault |
| done_fcode | output | 3 | Fault code: bit0 protection, bit1 write, bit2 user |
| done_paddr | output | 32 | Physical address when no fault |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions check several properties on every cycle. Requests are taken only in idle with no memory access open, the done pulse lasts one cycle, and the memory request stays stable while it waits. A pass-through request completes in the next cycle with its own address. Every write-back carries the accessed bit, and the fault address matches the request at each faulting completion. Other behaviours need the bench's scenarios, which run a behavioural model against a responding memory. These include the exact sequence of entry reads and writes for each entry state, dirty marking only at the second level and only for writes, and the fault-code classes. They also cover protection at each level and the survival of the fault address across walks that succeed.

// File: rtl/pt_walker_pkg.sv
// Package: shared widths, entry bit positions, fault-code bits and walker states.
// Assumes 4 KB pages, 32-bit entries and two index fields of equal width.
package pt_walker_pkg;
    parameter int ADDR_W  = 32;
    parameter int OFF_W   = 12;
    parameter int IDX_W   = 10;
    parameter int FC_W    = 3;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int ENT_SH  = OFF_W - IDX_W;
    localparam int DIR_HI  = ADDR_W - 1;
    localparam int DIR_LO  = OFF_W + IDX_W;
    localparam int TBL_HI  = DIR_LO - 1;
    localparam int TBL_LO  = OFF_W;

    // entry bit positions
    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

    // fault code bit positions
    localparam int FC_PROT = 0;
    localparam int FC_WR   = 1;
    localparam int FC_USER = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WR,
        ST_TBL_RD,
        ST_TBL_WR,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/ptw_entry_check.sv
// Entry evaluator: judges one page-structure entry for a request.
// It reports presence and permission, and builds the entry value after the usage-bit update.
// IS_LEAF selects the second-level variant, which also marks the entry dirty on a write.
// Assumes the entry is valid only while the controller is in the matching read state.
module ptw_entry_check
    import pt_walker_pkg::*;
#(
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              is_write,
    input  logic              is_user,
    output logic              present,
    output logic              allow,
    output logic [ADDR_W-1:0] new_entry,
    output logic              changed
);
    logic set_dirty;

    // choose whether this level may mark the entry dirty
    generate
        if (IS_LEAF) begin : g_leaf
            assign set_dirty = is_write;
        end else begin : g_dir
            assign set_dirty = 1'b0;
        end
    endgenerate

    // presence, permission and updated value
    always_comb begin
        present   = entry[BIT_P];
        allow     = !is_user || (entry[BIT_US] && (!is_write || entry[BIT_RW]));
        new_entry = entry;
        new_entry[BIT_A] = 1'b1;
        if (set_dirty) begin
            new_entry[BIT_D] = 1'b1;
        end
        changed   = (new_entry != entry);
    end
endmodule

// File: rtl/ptw_fault_reg.sv
// Fault address register: captures the linear address of a faulting walk.
// Assumes fault_set pulses at the edge that moves the walker into its response state.
module ptw_fault_reg
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_set,
    input  logic [ADDR_W-1:0] fault_lin,
    output logic [ADDR_W-1:0] fault_addr
);
    logic [ADDR_W-1:0] addr_q;

    // hold the most recent faulting linear address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (fault_set) begin
            addr_q <= fault_lin;
        end
    end

    assign fault_addr = addr_q;
endmodule

// File: rtl/ptw_ctrl.sv
// Walk controller: accepts one request, sequences the directory and table accesses and
// any write-backs, then presents a single-cycle response.
// Assumes the memory holds mem_rdata valid in the cycle mem_ack is high and accepts
// one access per acknowledge.
module ptw_ctrl
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paging_en,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_write,
    input  logic               req_user,
    output logic               done,
    output logic               done_fault,
    output logic [FC_W-1:0]    done_fcode,
    output logic [ADDR_W-1:0]  done_paddr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata,
    input  logic               dir_present,
    input  logic               dir_allow,
    input  logic               dir_changed,
    input  logic [ADDR_W-1:0]  dir_new,
    input  logic               tbl_present,
    input  logic               tbl_allow,
    input  logic               tbl_changed,
    input  logic [ADDR_W-1:0]  tbl_new,
    output logic               cur_write,
    output logic               cur_user,
    output logic [ADDR_W-1:0]  cur_lin,
    output logic               fault_set
);
    walk_state_t        state_q;
    logic [ADDR_W-1:0]  lin_q;
    logic               wr_q;
    logic               user_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [ADDR_W-1:0]  wb_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic               fault_q;
    logic [FC_W-1:0]    fcode_q;
    logic               dir_fault;
    logic               tbl_fault;
    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  tbl_addr;

    // entry addresses for the two levels
    always_comb begin
        dir_addr = {dir_frame,   lin_q[DIR_HI:DIR_LO], {ENT_SH{1'b0}}};
        tbl_addr = {tbl_frame_q, lin_q[TBL_HI:TBL_LO], {ENT_SH{1'b0}}};
    end

    // fault decisions at each read acknowledge
    always_comb begin
        dir_fault = mem_ack && (state_q == ST_DIR_RD) && (!dir_present || !dir_allow);
        tbl_fault = mem_ack && (state_q == ST_TBL_RD) && (!tbl_present || !tbl_allow);
        fault_set = dir_fault || tbl_fault;
    end

    // walk sequencing and captured request and response state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lin_q       <= '0;
            wr_q        <= 1'b0;
            user_q      <= 1'b0;
            tbl_frame_q <= '0;
            wb_q        <= '0;
            paddr_q     <= '0;
            fault_q     <= 1'b0;
            fcode_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q   <= req_lin;
                        wr_q    <= req_write;
                        user_q  <= req_user;
                        fault_q <= 1'b0;
                        fcode_q <= '0;
                        paddr_q <= req_lin;
                        state_q <= paging_en ? ST_DIR_RD : ST_RESP;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        tbl_frame_q <= mem_rdata[ADDR_W-1:OFF_W];
                        wb_q        <= dir_new;
                        if (dir_fault) begin
                            fault_q <= 1'b1;
                            fcode_q[FC_PROT] <= dir_present;
                            fcode_q[FC_WR]   <= wr_q;
                            fcode_q[FC_USER] <= user_q;
                            paddr_q <= '0;
                            state_q <= ST_RESP;
                        end else if (dir_changed) begin
                            state_q <= ST_DIR_WR;
                        end else begin
                            state_q <= ST_TBL_RD;
                        end
                    end
                end
                ST_DIR_WR: begin
                    if (mem_ack) begin
                        state_q <= ST_TBL_RD;
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        wb_q <= tbl_new;
                        if (tbl_fault) begin
                            fault_q <= 1'b1;
                            fcode_q[FC_PROT] <= tbl_present;
                            fcode_q[FC_WR]   <= wr_q;
                            fcode_q[FC_USER] <= user_q;
                            paddr_q <= '0;
                            state_q <= ST_RESP;
                        end else begin
                            paddr_q <= {mem_rdata[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
                            state_q <= tbl_changed ? ST_TBL_WR : ST_RESP;
                        end
                    end
                end
                ST_TBL_WR: begin
                    if (mem_ack) begin
                        state_q <= ST_RESP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // memory port drive from the current state
    always_comb begin
        mem_req   = (state_q == ST_DIR_RD) || (state_q == ST_DIR_WR) ||
                    (state_q == ST_TBL_RD) || (state_q == ST_TBL_WR);
        mem_we    = (state_q == ST_DIR_WR) || (state_q == ST_TBL_WR);
        mem_addr  = ((state_q == ST_DIR_RD) || (state_q == ST_DIR_WR)) ? dir_addr : tbl_addr;
        mem_wdata = wb_q;
    end

    // response and request-side outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_RESP);
        done_fault = fault_q;
        done_fcode = fcode_q;
        done_paddr = paddr_q;
        cur_write  = wr_q;
        cur_user   = user_q;
        cur_lin    = lin_q;
    end

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=> (done && !done_fault && done_paddr == $past(req_lin))); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_A]); // R5
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top: joins the walk controller, one entry evaluator per
// level and the fault address register.
// Assumes a single requester and a single memory responder.
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paging_en,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_write,
    input  logic               req_user,
    output logic               done,
    output logic               done_fault,
    output logic [FC_W-1:0]    done_fcode,
    output logic [ADDR_W-1:0]  done_paddr,
    output logic [ADDR_W-1:0]  fault_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    logic              dir_present, dir_allow, dir_changed;
    logic              tbl_present, tbl_allow, tbl_changed;
    logic [ADDR_W-1:0] dir_new, tbl_new;
    logic              cur_write, cur_user, fault_set;
    logic [ADDR_W-1:0] cur_lin;

    ptw_entry_check #(.IS_LEAF(1'b0)) u_dir_chk (
        .entry     (mem_rdata),
        .is_write  (cur_write),
        .is_user   (cur_user),
        .present   (dir_present),
        .allow     (dir_allow),
        .new_entry (dir_new),
        .changed   (dir_changed)
    );

    ptw_entry_check #(.IS_LEAF(1'b1)) u_tbl_chk (
        .entry     (mem_rdata),
        .is_write  (cur_write),
        .is_user   (cur_user),
        .present   (tbl_present),
        .allow     (tbl_allow),
        .new_entry (tbl_new),
        .changed   (tbl_changed)
    );

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .paging_en   (paging_en),
        .dir_frame   (dir_frame),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_lin     (req_lin),
        .req_write   (req_write),
        .req_user    (req_user),
        .done        (done),
        .done_fault  (done_fault),
        .done_fcode  (done_fcode),
        .done_paddr  (done_paddr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .dir_present (dir_present),
        .dir_allow   (dir_allow),
        .dir_changed (dir_changed),
        .dir_new     (dir_new),
        .tbl_present (tbl_present),
        .tbl_allow   (tbl_allow),
        .tbl_changed (tbl_changed),
        .tbl_new     (tbl_new),
        .cur_write   (cur_write),
        .cur_user    (cur_user),
        .cur_lin     (cur_lin),
        .fault_set   (fault_set)
    );

    ptw_fault_reg u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_set  (fault_set),
        .fault_lin  (cur_lin),
        .fault_addr (fault_addr)
    );

    AST_FAULT_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (fault_addr == cur_lin)); // R9
endmodule

// File: tb/pt_walker_bench.sv
// Bench: a behavioural memory answers the walker. A reference model predicts every entry
// access and the response of each request, and both are compared as they happen.
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [19:0] dir_frame = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        done, done_fault;
    logic [2:0]  done_fcode;
    logic [31:0] done_paddr, fault_addr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int lat = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] q_addr [$];
    logic        q_we [$];
    logic [31:0] q_wd [$];

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_frame(dir_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .done(done), .done_fault(done_fault),
        .done_fcode(done_fcode), .done_paddr(done_paddr), .fault_addr(fault_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder with a settable wait; compares each access with the model (R3 R5 R6 R10)
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (w < lat) begin
                    w++;
                end else begin
                    w = 0;
                    mem_ack = 1'b1;
                    if (q_addr.size() == 0) begin
                        chk(1'b0, "R4 unexpected access", mem_addr, 32'h0);
                    end else begin
                        logic [31:0] ea, ed;
                        logic ew;
                        ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_wd.pop_front();
                        chk(mem_addr == ea, "R3 access address", mem_addr, ea);
                        chk(mem_we == ew, "R5 access kind", {31'h0, mem_we}, {31'h0, ew});
                        if (ew) chk(mem_wdata == ed, "R6 write-back value", mem_wdata, ed);
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata = rd(mem_addr);
                end
            end
        end
    end

    // reference model: predicts the accesses and the response of one request
    task automatic predict(input logic [31:0] lin, input bit wr, input bit usr, input bit pg,
                           output bit f, output logic [2:0] code, output logic [31:0] pa);
        logic [31:0] da, de, ta, te, nv;
        f = 0; code = 3'b000; pa = lin;
        if (!pg) return;
        da = {dir_frame, lin[31:22], 2'b00};
        de = rd(da);
        q_addr.push_back(da); q_we.push_back(0); q_wd.push_back(0);
        if (!de[0]) begin f = 1; code = {usr, wr, 1'b0}; return; end
        if (usr && (!de[2] || (wr && !de[1]))) begin f = 1; code = {usr, wr, 1'b1}; return; end
        if (!de[5]) begin q_addr.push_back(da); q_we.push_back(1); q_wd.push_back(de | 32'h20); end
        ta = {de[31:12], lin[21:12], 2'b00};
        te = rd(ta);
        q_addr.push_back(ta); q_we.push_back(0); q_wd.push_back(0);
        if (!te[0]) begin f = 1; code = {usr, wr, 1'b0}; return; end
        if (usr && (!te[2] || (wr && !te[1]))) begin f = 1; code = {usr, wr, 1'b1}; return; end
        nv = te | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nv != te) begin q_addr.push_back(ta); q_we.push_back(1); q_wd.push_back(nv); end
        pa = {te[31:12], lin[11:0]};
    endtask

    // issue one request and compare its response (R1 R2 R4 R7 R8 R9)
    task automatic run(input logic [31:0] lin, input bit wr, input bit usr, input bit pg, input string tag);
        bit f; logic [2:0] code; logic [31:0] pa;
        logic [31:0] fa_before;
        int n;
        fa_before = fault_addr;
        predict(lin, wr, usr, pg, f, code, pa);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R1 ready when idle"}, {31'h0, req_ready}, 32'h1);
        req_valid = 1; req_lin = lin; req_write = wr; req_user = usr; paging_en = pg;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 1'b0, {tag, " R1 busy after accept"}, {31'h0, req_ready}, 32'h0);
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!pg) chk(n == 1, {tag, " R2 one-cycle latency"}, n, 1);
        chk(done == 1'b1, {tag, " R1 done seen"}, {31'h0, done}, 32'h1);
        chk(done_fault == f, {tag, " R4 fault flag"}, {31'h0, done_fault}, {31'h0, f});
        if (f) begin
            chk(done_fcode == code, {tag, " R8 fault code"}, {29'h0, done_fcode}, {29'h0, code});
            chk(fault_addr == lin, {tag, " R9 fault address"}, fault_addr, lin);
        end else begin
            chk(done_paddr == pa, {tag, " R3 physical address"}, done_paddr, pa);
            chk(fault_addr == fa_before, {tag, " R9 fault address kept"}, fault_addr, fa_before);
        end
        chk(q_addr.size() == 0, {tag, " R4 accesses complete"}, q_addr.size(), 0);
        q_addr.delete(); q_we.delete(); q_wd.delete();
        @(negedge clk);
        chk(done == 1'b0, {tag, " R1 done single cycle"}, {31'h0, done}, 32'h0);
    endtask

    function automatic logic [31:0] mk(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // directory at 0x10000: entry 1 -> table 0x20000, entry 2 absent, entry 3 supervisor-only
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0001_000C] = 32'h0003_0001;
        mem[32'h0002_000C] = 32'h0055_5007;
        mem[32'h0002_0014] = 32'h0066_6003;
        mem[32'h0002_0018] = 32'h0077_7005;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req, "R1 reset state", {29'h0, req_ready, done, mem_req}, 32'h4);
        chk(fault_addr == 0, "R9 reset fault address", fault_addr, 0);

        run(32'hDEAD_BEEF, 1, 1, 0, "pass");                 // R2
        run(mk(1, 3, 12'habc), 0, 0, 1, "first-read");      // R5 both accessed bits
        run(mk(1, 3, 12'h123), 0, 0, 1, "repeat-read");     // R6 no write-back
        run(mk(1, 3, 12'h456), 1, 0, 1, "first-write");     // R6 dirty on table only
        chk(rd(32'h0001_0004) == 32'h0002_0027, "R6 directory dirty untouched", rd(32'h0001_0004), 32'h0002_0027);
        chk(rd(32'h0002_000C) == 32'h0055_5067, "R6 table dirty set", rd(32'h0002_000C), 32'h0055_5067);
        run(mk(1, 3, 12'h789), 1, 0, 1, "repeat-write");    // R6
        run(mk(2, 0, 12'h010), 0, 0, 1, "dir-absent");      // R4 R8
        run(mk(1, 4, 12'h020), 1, 1, 1, "tbl-absent");      // R4 R8
        run(mk(1, 5, 12'h030), 0, 1, 1, "user-super");      // R7 R8
        run(mk(1, 6, 12'h040), 1, 1, 1, "user-ro");         // R7
        chk(rd(32'h0002_0018) == 32'h0077_7005, "R7 no write-back on fault", rd(32'h0002_0018), 32'h0077_7005);
        run(mk(1, 6, 12'h050), 1, 0, 1, "super-ro");        // R7 supervisor allowed
        run(mk(1, 3, 12'h060), 1, 1, 1, "user-rw");         // R7 R9 kept
        run(mk(3, 1, 12'h070), 0, 1, 1, "dir-super");       // R7 directory level
        chk(rd(32'h0001_000C) == 32'h0003_0001, "R7 directory not written", rd(32'h0001_000C), 32'h0003_0001);
        run(32'h1234_5678, 0, 0, 0, "pass-after-fault");    // R2 R9
        lat = 2;
        mem[32'h0001_0008] = 32'h0004_0007;
        mem[32'h0004_0FFC] = 32'h0088_8007;
        run(mk(2, 1023, 12'hfff), 1, 1, 1, "slow-mem");     // R10 with waits
        run(mk(2, 1023, 12'h001), 0, 0, 1, "slow-repeat");  // R10
        lat = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule